// File: doc/BRIEF.md
# ATA PIO Device Register Target

This block behaves as the drive end of a parallel ATA cable in programmed-I/O mode. A host controller drives a two-bit chip-select, a three-bit register address, active-low read and write strobes and a 16-bit data bus. The block samples all of these on its own system clock. It holds the command-block registers, answers status reads, and runs sector read and sector write commands against a small sector store inside the block. Words pass to and from the host through a sector buffer.

A host sets up a transfer by loading the count and the four address registers and then writing a command code. For a read, the block copies the addressed sectors into the buffer while it reports busy. It then raises the data-request flag and returns one word for each data-port read. For a write, it raises data-request at once and takes one word for each data-port write. After the last word it copies the buffer back into the store while it reports busy.

Top module: `ata_pio_target`

## Requirements
- R1: After synchronous reset the status register, read at select code {cs,da} = 0x17 (cs=2'b10, da=3'd7), returns 0x0050 (DRDY bit 6 and DSC bit 4 set). The data output is 0x0000 until the first read access.
- R2: Writes decode as follows: 0x12 is the sector count, 0x13 the sector number, 0x14 cylinder low, 0x15 cylinder high and 0x16 drive/head. The low byte of data is kept. The LBA is {head[3:0], cyl_hi, cyl_lo, sect}, and only its low 3 bits pick one of the 8 sectors of 256 words.
- R3: A register action happens only at the clock where a strobe is first seen low after being high. While read strobe stays low the output bus holds its value, and a long strobe moves one word only.
- R4: Command 0x20 (low data byte, written at 0x17) makes status read 0x00D0 (BSY bit 7) for exactly one clock per buffered word while the buffer fills. Status then reads 0x0058 (DRQ bit 3 added to 0x50).
- R5: In a read transfer each data-port (0x10) read returns the next word in sector order. DRQ stays set until the last word has been read, and status is then 0x0050.
- R6: Command 0x30 sets status to 0x0058 at once. Each data-port write stores one word. After the last word, status reads 0x00D0 for one clock per word during the commit and then 0x0050, and the words are in the store.
- R7: The effective sector count is 1 for a count of 0, 4 for counts above 4, and the count itself otherwise. A transfer moves that count times 256 words through consecutive sectors, wrapping from sector 7 to sector 0.
- R8: Writes to 0x11, 0x0E and 0x1E, and command codes other than 0x20 and 0x30, change no register, pointer or status.
- R9: Data-port reads and writes outside a read or write transfer are ignored. A read at any select other than data or status leaves the output bus unchanged.
- R10: BSY and DRQ are never set together, and neither buffer pointer ever exceeds the transfer word count.
- R11: A command written while BSY is set is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes and bus are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 2 | Chip-select pair, upper two bits of the select code |
| da | input | 3 | Register address, lower three bits of the select code |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| din | input | 16 | Data from host |
| dout | output | 16 | Data to host, registered at the read strobe's falling edge |

## Verification
A wrong pointer or a wrong LBA base appears as a word mismatch on the first data read of the affected sector. A wrong word count shows up as DRQ dropping too early or too late, and the bench reads status one word before the end of every transfer to catch this. A stuck or wrongly timed copy engine shows up within one status poll as a missing 0x00D0, or as a busy interval whose length differs from the word count. A misdecoded ignored register would corrupt a taskfile field, and the next sector read would return data from the wrong sector.

// File: rtl/ata_pkg.sv
package ata_pkg;
    localparam int WORD_W     = 16;
    localparam int SECT_WORDS = 256;
    localparam int WORD_AW    = $clog2(SECT_WORDS);
    localparam int SEL_W      = 5;

    localparam logic [SEL_W-1:0] SEL_DATA   = 5'h10;
    localparam logic [SEL_W-1:0] SEL_COUNT  = 5'h12;
    localparam logic [SEL_W-1:0] SEL_SECT   = 5'h13;
    localparam logic [SEL_W-1:0] SEL_CYL_LO = 5'h14;
    localparam logic [SEL_W-1:0] SEL_CYL_HI = 5'h15;
    localparam logic [SEL_W-1:0] SEL_HEAD   = 5'h16;
    localparam logic [SEL_W-1:0] SEL_CMD    = 5'h17;

    localparam logic [7:0] OP_READ  = 8'h20;
    localparam logic [7:0] OP_WRITE = 8'h30;

    localparam int ST_BSY  = 7;
    localparam int ST_DRDY = 6;
    localparam int ST_DSC  = 4;
    localparam int ST_DRQ  = 3;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FILL,
        PH_HOST_RD,
        PH_HOST_WR,
        PH_COMMIT
    } phase_e;

    typedef struct packed {
        logic [7:0] head;
        logic [7:0] cyl_hi;
        logic [7:0] cyl_lo;
        logic [7:0] sect;
        logic [7:0] count;
    } taskfile_t;

    function automatic logic [27:0] tf_lba(taskfile_t t);
        return {t.head[3:0], t.cyl_hi, t.cyl_lo, t.sect};
    endfunction

    function automatic int unsigned eff_sectors(logic [7:0] c, int unsigned lim);
        if (c == 8'd0) return 1;
        if (int'(c) > int'(lim)) return lim;
        return int'(c);
    endfunction

    function automatic logic [7:0] pack_status(logic busy, logic req);
        logic [7:0] s;
        s          = '0;
        s[ST_BSY]  = busy;
        s[ST_DRDY] = 1'b1;
        s[ST_DSC]  = 1'b1;
        s[ST_DRQ]  = req;
        return s;
    endfunction
endpackage

// File: rtl/ata_strobe_fall.sv
module ata_strobe_fall (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n,
    output logic start
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= strobe_n;
    end

    assign start = prev_q & ~strobe_n;
endmodule

// File: rtl/ata_word_ram.sv
module ata_word_ram #(
    parameter int W     = 16,
    parameter int DEPTH = 256
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [W-1:0]             wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [W-1:0]             rdata
);
    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/ata_pio_target.sv
module ata_pio_target
    import ata_pkg::*;
#(
    parameter int NUM_SECT  = 8,
    parameter int MAX_BURST = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  cs,
    input  logic [2:0]  da,
    input  logic        rd_n,
    input  logic        wr_n,
    input  logic [15:0] din,
    output logic [15:0] dout
);
    localparam int SECT_AW   = $clog2(NUM_SECT);
    localparam int MEM_WORDS = NUM_SECT * SECT_WORDS;
    localparam int MEM_AW    = $clog2(MEM_WORDS);
    localparam int BUF_WORDS = MAX_BURST * SECT_WORDS;
    localparam int BUF_AW    = $clog2(BUF_WORDS);
    localparam int CNT_W     = BUF_AW + 1;

    logic             rd_go, wr_go;
    logic [SEL_W-1:0] sel;
    taskfile_t        tf;
    phase_e           phase;
    logic [MEM_AW-1:0] base_q;
    logic [CNT_W-1:0] words_q, rd_ptr, wr_ptr, cp_q;
    logic             busy, req;
    logic [7:0]       status_w;
    logic [27:0]      lba_w;
    logic [MEM_AW-1:0] base_next;
    logic [CNT_W-1:0] words_next;
    logic             cmd_ok, data_rd, data_wr;

    logic              mem_we;
    logic [MEM_AW-1:0] mem_addr;
    logic [WORD_W-1:0] mem_rdata;
    logic              buf_we;
    logic [BUF_AW-1:0] buf_waddr, buf_raddr;
    logic [WORD_W-1:0] buf_wdata, buf_rdata;

    ata_strobe_fall u_rd_edge (.clk(clk), .rst(rst), .strobe_n(rd_n), .start(rd_go));
    ata_strobe_fall u_wr_edge (.clk(clk), .rst(rst), .strobe_n(wr_n), .start(wr_go));

    assign sel        = {cs, da};
    assign busy       = (phase == PH_FILL) || (phase == PH_COMMIT);
    assign req        = (phase == PH_HOST_RD) || (phase == PH_HOST_WR);
    assign status_w   = pack_status(busy, req);
    assign lba_w      = tf_lba(tf);
    assign base_next  = MEM_AW'({lba_w[SECT_AW-1:0], {WORD_AW{1'b0}}});
    assign words_next = CNT_W'(eff_sectors(tf.count, MAX_BURST) * SECT_WORDS);
    assign cmd_ok     = wr_go && (sel == SEL_CMD) && !busy &&
                        ((din[7:0] == OP_READ) || (din[7:0] == OP_WRITE));
    assign data_rd    = rd_go && (sel == SEL_DATA) && (phase == PH_HOST_RD);
    assign data_wr    = wr_go && (sel == SEL_DATA) && (phase == PH_HOST_WR);

    // Sector store: read during fill, written during commit, same address
    assign mem_addr = base_q + MEM_AW'(cp_q);
    assign mem_we   = (phase == PH_COMMIT);

    ata_word_ram #(.W(WORD_W), .DEPTH(MEM_WORDS)) u_store (
        .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(buf_rdata),
        .raddr(mem_addr), .rdata(mem_rdata)
    );

    // Sector buffer: copy engine and host share the ports by phase
    assign buf_we    = (phase == PH_FILL) || data_wr;
    assign buf_waddr = (phase == PH_FILL) ? cp_q[BUF_AW-1:0] : wr_ptr[BUF_AW-1:0];
    assign buf_wdata = (phase == PH_FILL) ? mem_rdata : din;
    assign buf_raddr = (phase == PH_COMMIT) ? cp_q[BUF_AW-1:0] : rd_ptr[BUF_AW-1:0];

    ata_word_ram #(.W(WORD_W), .DEPTH(BUF_WORDS)) u_buffer (
        .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
        .raddr(buf_raddr), .rdata(buf_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tf      <= '0;
            phase   <= PH_IDLE;
            base_q  <= '0;
            words_q <= '0;
            rd_ptr  <= '0;
            wr_ptr  <= '0;
            cp_q    <= '0;
            dout    <= '0;
        end else begin
            if (wr_go) begin
                case (sel)
                    SEL_COUNT:  tf.count  <= din[7:0];
                    SEL_SECT:   tf.sect   <= din[7:0];
                    SEL_CYL_LO: tf.cyl_lo <= din[7:0];
                    SEL_CYL_HI: tf.cyl_hi <= din[7:0];
                    SEL_HEAD:   tf.head   <= din[7:0];
                    default: ;
                endcase
            end

            if (cmd_ok) begin
                base_q  <= base_next;
                words_q <= words_next;
                rd_ptr  <= '0;
                wr_ptr  <= '0;
                cp_q    <= '0;
                phase   <= (din[7:0] == OP_READ) ? PH_FILL : PH_HOST_WR;
            end else begin
                case (phase)
                    PH_FILL: begin
                        cp_q <= cp_q + CNT_W'(1);
                        if (cp_q == words_q - CNT_W'(1)) phase <= PH_HOST_RD;
                    end
                    PH_COMMIT: begin
                        cp_q <= cp_q + CNT_W'(1);
                        if (cp_q == words_q - CNT_W'(1)) phase <= PH_IDLE;
                    end
                    PH_HOST_WR: begin
                        if (data_wr) begin
                            wr_ptr <= wr_ptr + CNT_W'(1);
                            if (wr_ptr == words_q - CNT_W'(1)) begin
                                phase <= PH_COMMIT;
                                cp_q  <= '0;
                            end
                        end
                    end
                    PH_HOST_RD: begin
                        if (data_rd) begin
                            rd_ptr <= rd_ptr + CNT_W'(1);
                            if (rd_ptr == words_q - CNT_W'(1)) phase <= PH_IDLE;
                        end
                    end
                    default: ;
                endcase
            end

            if (rd_go && (sel == SEL_CMD)) dout <= {8'h00, status_w};
            else if (data_rd)              dout <= buf_rdata;
        end
    end
endmodule

// File: rtl/ata_pio_target_chk.sv
module ata_pio_target_chk #(
    parameter int CNT_W = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             rd_n,
    input logic [15:0]      dout,
    input logic [7:0]       status,
    input logic [CNT_W-1:0] rp,
    input logic [CNT_W-1:0] wp,
    input logic [CNT_W-1:0] words
);
    logic           prev_rd, prev_bsy;
    logic [CNT_W:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_rd  <= 1'b1;
            prev_bsy <= 1'b0;
            busy_run <= '0;
        end else begin
            prev_rd  <= rd_n;
            prev_bsy <= status[7];
            busy_run <= status[7] ? busy_run + 1'b1 : '0;
        end
    end

    assert_status_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> status == 8'h50);

    // R3: without a fresh falling edge of the read strobe the bus holds
    assert_dout_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_n || !prev_rd) |=> $stable(dout));

    // R4 and R6: each busy interval lasts one clock per word
    assert_busy_length_R4: assert property (@(posedge clk) disable iff (rst)
        (prev_bsy && !status[7]) |-> ({1'b0, words} == busy_run));

    assert_bsy_drq_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(status[7] && status[3]));

    assert_ptr_bound_R10: assert property (@(posedge clk) disable iff (rst)
        (rp <= words) && (wp <= words));
endmodule

bind ata_pio_target ata_pio_target_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .rd_n(rd_n), .dout(dout), .status(status_w),
    .rp(rd_ptr), .wp(wr_ptr), .words(words_q)
);

// File: tb/ata_pio_target_bench.sv
module ata_pio_target_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cs = 2'b00;
    logic [2:0]  da = 3'd0;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [15:0] din = 16'h0000;
    logic [15:0] dout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] model [2048];

    always #2 clk = ~clk;

    ata_pio_target u_ata_pio_target (
        .clk(clk), .rst(rst), .cs(cs), .da(da),
        .rd_n(rd_n), .wr_n(wr_n), .din(din), .dout(dout)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %04h expected %04h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [4:0] sel, input logic [15:0] v);
        @(negedge clk);
        cs = sel[4:3]; da = sel[2:0]; din = v; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
    endtask

    task automatic bus_rd(input logic [4:0] sel, output logic [15:0] v);
        @(negedge clk);
        cs = sel[4:3]; da = sel[2:0]; rd_n = 1'b0;
        @(negedge clk);
        v = dout; rd_n = 1'b1;
    endtask

    function automatic logic [15:0] pat(int phys, int i, int seed);
        return 16'((phys * 4099 + i * 257 + seed * 31 + 16'h01A5) ^ (i << 7));
    endfunction

    task automatic setup(input logic [7:0] sect, input logic [7:0] cnt);
        bus_wr(5'h13, {8'hEE, sect});
        bus_wr(5'h14, 16'h00A5 ^ {8'h00, sect});
        bus_wr(5'h15, 16'h003C);
        bus_wr(5'h16, 16'h00F0 | {8'h00, sect[3:0]});
        bus_wr(5'h12, {8'h00, cnt});
    endtask

    task automatic wait_not_busy(input string req, input logic [15:0] exp);
        logic [15:0] v;
        v = 16'h0080;
        for (int k = 0; k < 3000 && v[7]; k++) bus_rd(5'h17, v);
        chk(req, v, exp);
    endtask

    task automatic do_write(input logic [7:0] sect, input logic [7:0] cnt, input int nsect, input int seed);
        logic [15:0] v;
        int idx;
        setup(sect, cnt);
        bus_wr(5'h17, 16'h0030);
        bus_rd(5'h17, v);
        chk("R6 drq after write cmd", v, 16'h0058);
        for (int i = 0; i < nsect * 256; i++) begin
            idx = (int'(sect[2:0]) * 256 + i) % 2048;
            model[idx] = pat(idx / 256, i, seed);
            if (i == nsect * 256 - 1) begin
                bus_rd(5'h17, v);
                chk("R6 drq before last word", v, 16'h0058);
            end
            bus_wr(5'h10, model[idx]);
        end
        bus_rd(5'h17, v);
        chk("R6 busy during commit", v, 16'h00D0);
        wait_not_busy("R6 idle after commit", 16'h0050);
    endtask

    task automatic do_read(input logic [7:0] sect, input logic [7:0] cnt, input int nsect);
        logic [15:0] v;
        int idx;
        setup(sect, cnt);
        bus_wr(5'h17, 16'h0020);
        bus_rd(5'h17, v);
        chk("R4 busy during fill", v, 16'h00D0);
        wait_not_busy("R4 drq after fill", 16'h0058);
        for (int i = 0; i < nsect * 256; i++) begin
            idx = (int'(sect[2:0]) * 256 + i) % 2048;
            if (i == nsect * 256 - 1) begin
                bus_rd(5'h17, v);
                chk("R5/R7 drq before last word", v, 16'h0058);
            end
            bus_rd(5'h10, v);
            chk("R5 R2 R7 read word", v, model[idx]);
        end
        bus_rd(5'h17, v);
        chk("R5 idle after last word", v, 16'h0050);
    endtask

    initial begin
        logic [15:0] v;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 dout after reset", dout, 16'h0000);
        bus_rd(5'h17, v);
        chk("R1 status after reset", v, 16'h0050);

        bus_wr(5'h17, 16'h0091);
        bus_rd(5'h17, v);
        chk("R8 unknown command", v, 16'h0050);

        // R2 R6: sweep every sector with junk in the ignored LBA bits
        for (int s = 0; s < 8; s++) do_write(8'(s | ((s + 3) << 3)), 8'd1, 1, 1);
        for (int s = 7; s >= 0; s--) do_read(8'(s | ((7 - s) << 4)), 8'd1, 1);

        // R3: long read strobe moves one word and holds the bus
        setup(8'd1, 8'd1);
        bus_wr(5'h17, 16'h0020);
        wait_not_busy("R4 drq after fill", 16'h0058);
        @(negedge clk);
        cs = 2'b10; da = 3'd0; rd_n = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R3 bus held during long strobe", dout, model[256]);
        end
        rd_n = 1'b1;
        bus_rd(5'h10, v);
        chk("R3 one word per strobe", v, model[257]);

        // R7: three sectors wrapping past the end; long write strobe on word 0
        setup(8'd6, 8'd3);
        bus_wr(5'h17, 16'h0030);
        @(negedge clk);
        cs = 2'b10; da = 3'd0; din = 16'h1234; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        model[6 * 256] = 16'h1234;
        for (int i = 1; i < 768; i++) begin
            int idx;
            idx = (6 * 256 + i) % 2048;
            model[idx] = pat(idx / 256, i, 2);
            bus_wr(5'h10, model[idx]);
        end
        wait_not_busy("R3 R7 long write strobe stores once", 16'h0050);
        do_read(8'd6, 8'd9, 4);
        do_read(8'd3, 8'd0, 1);

        // R8 R9: ignored registers and stray data accesses
        setup(8'd2, 8'd1);
        bus_wr(5'h11, 16'h0005);
        bus_wr(5'h0E, 16'h0005);
        bus_wr(5'h1E, 16'h0005);
        bus_wr(5'h10, 16'hDEAD);
        bus_rd(5'h17, v);
        chk("R8 status after ignored writes", v, 16'h0050);
        bus_rd(5'h10, v);
        chk("R9 data read outside transfer", v, 16'h0050);
        bus_rd(5'h12, v);
        chk("R9 unreadable select", v, 16'h0050);
        bus_wr(5'h17, 16'h0020);
        wait_not_busy("R8 drq after fill", 16'h0058);
        for (int i = 0; i < 256; i++) begin
            bus_rd(5'h10, v);
            chk("R8 R9 sector intact", v, model[512 + i]);
        end

        // R11: write command during fill is ignored
        setup(8'd4, 8'd1);
        bus_wr(5'h17, 16'h0020);
        bus_wr(5'h17, 16'h0030);
        wait_not_busy("R11 still read transfer", 16'h0058);
        for (int i = 0; i < 256; i++) begin
            bus_rd(5'h10, v);
            chk("R11 read data", v, model[1024 + i]);
        end
        bus_rd(5'h17, v);
        chk("R11 R10 idle at end", v, 16'h0050);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule